// File: doc/BRIEF.md
# Relocatable Port Decoder with Self-Test Data-Clock Generator

This block sits between an ISA-style host I/O bus and a serial optical-drive interface. It matches a group of sixteen I/O ports whose base is relocatable: a three-bit select places the group at 0x300 plus sixteen times the select. Within the group it produces strobe-qualified enables for the serial controller's data and control registers, for the attention-register read and for the ready-flag read. It also produces a one-cycle reset pulse for the capture data path.

The serial controller's DTR output picks the operating mode. When DTR is inactive (high), the block is in self-test mode. In this mode the card owns the drive-side lines and DMA is blocked. Each new access to one of two stepping ports generates one synthetic data-clock pulse, low first and then high again. The pulse carries a predictable data and attention pattern, so a driver can exercise the whole capture path with no drive attached. When DTR is active, the drive's own data clock, data and attention lines pass straight through.

Host strobes are treated as synchronous to `clk`. An access event is the first cycle in which either strobe is seen asserted.

Top module: `cdbus_port_decoder`

## Requirements
- R1: The group matches only when `base_sel` is 0 to 4 and `addr[9:4]` equals 0x30 plus `base_sel`. Select values 5 to 7 match no address, and an address outside the group drives no output.
- R2: While either strobe is held on a matched address, offset 2 raises `uart_data_sel` and offset 3 raises `uart_ctrl_sel`, for reads and writes alike.
- R3: A read strobe at offset 4 or 5 raises `rdy_rd`, and a read at offset 6 or 7 raises `attn_rd`. Writes to offsets 4 to 7 raise neither. At most one of the four enables is high at any time.
- R4: A new access of either direction to offset 0 drives `dp_reset` high for exactly one cycle, starting in the cycle after the first clock edge that sees the strobe.
- R5: `card_owns_bus` equals `uart_dtr_n` and `dma_permit` is its inverse. With `uart_dtr_n` low, `dclk_out`, `data_out` and `attn_out` follow `drv_dclk`, `drv_data` and `drv_attn` unchanged.
- R6: With `uart_dtr_n` high, a new read or write to offset 8 or 9 drops `dclk_out` in the cycle after the first edge that sees the strobe. The clock stays low for LOW_CYCLES cycles (default 2, never fewer than 2) and then returns high. `data_out` and `attn_out` change only when the clock falls, and they hold afterwards.
- R7: For the n-th generated pulse since reset (n from 0), `data_out` is 1 when n is even and 0 when n is odd. `attn_out` is 1 when n mod 128 is below 64 and 0 otherwise.
- R8: An offset-8/9 access while `uart_dtr_n` is low, or while a pulse is still in its low phase, makes no pulse and does not advance the pattern.
- R9: After reset, in self-test mode, `dclk_out` is 1, `data_out` and `attn_out` are 0, and `dp_reset` is 0.
- R10: A strobe held for several cycles counts as one access: it gives at most one `dp_reset` pulse and at most one data-clock pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 10 | Host I/O address |
| ior_n | input | 1 | Host read strobe, active low |
| iow_n | input | 1 | Host write strobe, active low |
| base_sel | input | 3 | Port group select, valid values 0 to 4 |
| uart_dtr_n | input | 1 | Serial controller DTR output; high selects self-test mode |
| drv_dclk | input | 1 | Data clock from the drive |
| drv_data | input | 1 | Serial data from the drive |
| drv_attn | input | 1 | Attention line from the drive |
| uart_data_sel | output | 1 | Enable for the serial controller data register |
| uart_ctrl_sel | output | 1 | Enable for the serial controller control/status register |
| rdy_rd | output | 1 | Read enable for the ready flag |
| attn_rd | output | 1 | Read enable for the attention register |
| dp_reset | output | 1 | One-cycle reset for the capture data path |
| card_owns_bus | output | 1 | High while the card drives the drive-side lines |
| dma_permit | output | 1 | High when DMA requests may pass |
| dclk_out | output | 1 | Data clock toward the capture logic |
| data_out | output | 1 | Serial data toward the capture logic |
| attn_out | output | 1 | Attention toward the capture logic |

## Verification
Random accesses are spread over every select value, every offset and both strobe directions. Some fall inside the matched group and some fall on random addresses, which separates a correct group compare from one that ignores the select range or the upper address bits. A long directed run of more than 256 stepping accesses crosses the 64-pulse and 128-pulse attention boundaries and the even/odd data alternation. DTR toggles between accesses with random drive-line values, which shows the pass-through path. It also shows that blocked stepping accesses leave the pattern unchanged. A re-access placed inside the low phase separates a generator that ignores it from one that restarts or double-counts.

// File: rtl/cdbus_pkg.sv
package cdbus_pkg;

  localparam int ADDR_W   = 10;
  localparam int SEL_W    = 3;
  localparam int OFF_W    = 4;
  localparam int SEL_LAST = 4;
  localparam logic [ADDR_W-1:0] BASE_ROOT = 10'h300;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_DPRST,
    EV_UDATA,
    EV_UCTRL,
    EV_RDY,
    EV_ATTN,
    EV_STEP
  } port_ev_e;

  // First port of the group picked by the select value.
  function automatic logic [ADDR_W-1:0] group_base(input logic [SEL_W-1:0] sel);
    return BASE_ROOT + ADDR_W'({sel, {OFF_W{1'b0}}});
  endfunction

  // Meaning of an offset inside the group, given the access direction.
  function automatic port_ev_e classify(input logic [OFF_W-1:0] off, input logic is_rd);
    case (off)
      4'd0:       return EV_DPRST;
      4'd2:       return EV_UDATA;
      4'd3:       return EV_UCTRL;
      4'd4, 4'd5: return is_rd ? EV_RDY : EV_NONE;
      4'd6, 4'd7: return is_rd ? EV_ATTN : EV_NONE;
      4'd8, 4'd9: return EV_STEP;
      default:    return EV_NONE;
    endcase
  endfunction

endpackage

// File: rtl/cdbus_addr_match.sv
module cdbus_addr_match
  import cdbus_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEL_W-1:0]  base_sel,
  input  logic              is_rd,
  output port_ev_e          ev
);

  logic [ADDR_W-1:0] base_addr;
  logic              sel_ok;
  logic              group_hit;

  assign base_addr = group_base(base_sel);
  assign sel_ok    = (int'(base_sel) <= SEL_LAST);
  assign group_hit = sel_ok && (addr[ADDR_W-1:OFF_W] == base_addr[ADDR_W-1:OFF_W]);
  assign ev        = group_hit ? classify(addr[OFF_W-1:0], is_rd) : EV_NONE;

endmodule

// File: rtl/cdbus_pulse_gen.sv
module cdbus_pulse_gen #(
  parameter int LOW_CYCLES = 2,
  parameter int ATTN_HALF  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_req,
  output logic gen_dclk,
  output logic gen_data,
  output logic gen_attn,
  output logic busy
);

  localparam int PERIOD = 2 * ATTN_HALF;
  localparam int IDX_W  = $clog2(PERIOD);
  localparam int CNT_W  = (LOW_CYCLES > 1) ? $clog2(LOW_CYCLES) : 1;

  logic [IDX_W-1:0] bit_idx;
  logic [CNT_W-1:0] low_cnt;
  logic             st_low;
  logic             data_q;
  logic             attn_q;
  logic             start;
  logic             finish;

  function automatic logic data_for(input logic [IDX_W-1:0] idx);
    return ~idx[0];
  endfunction

  function automatic logic attn_for(input logic [IDX_W-1:0] idx);
    return (int'(idx) < ATTN_HALF);
  endfunction

  function automatic logic [IDX_W-1:0] idx_next(input logic [IDX_W-1:0] idx);
    return (int'(idx) == PERIOD - 1) ? '0 : idx + 1'b1;
  endfunction

  assign start  = step_req && !st_low;
  assign finish = st_low && (low_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_low  <= 1'b0;
      low_cnt <= '0;
      bit_idx <= '0;
      data_q  <= 1'b0;
      attn_q  <= 1'b0;
    end else if (start) begin
      st_low  <= 1'b1;
      low_cnt <= CNT_W'(LOW_CYCLES - 1);
      data_q  <= data_for(bit_idx);
      attn_q  <= attn_for(bit_idx);
      bit_idx <= idx_next(bit_idx);
    end else if (finish) begin
      st_low  <= 1'b0;
    end else if (st_low) begin
      low_cnt <= low_cnt - 1'b1;
    end
  end

  assign gen_dclk = ~st_low;
  assign gen_data = data_q;
  assign gen_attn = attn_q;
  assign busy     = st_low;

  AST_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_low) |-> $past(st_low, 2)); // R6
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(st_low) |-> ($stable(data_q) && $stable(attn_q))); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (st_low && low_cnt != '0) |=> st_low); // R8

endmodule

// File: rtl/cdbus_bus_mux.sv
module cdbus_bus_mux (
  input  logic test_mode,
  input  logic gen_dclk,
  input  logic gen_data,
  input  logic gen_attn,
  input  logic drv_dclk,
  input  logic drv_data,
  input  logic drv_attn,
  output logic dclk_out,
  output logic data_out,
  output logic attn_out
);

  always_comb begin
    if (test_mode) begin
      dclk_out = gen_dclk;
      data_out = gen_data;
      attn_out = gen_attn;
    end else begin
      dclk_out = drv_dclk;
      data_out = drv_data;
      attn_out = drv_attn;
    end
  end

endmodule

// File: rtl/cdbus_port_decoder.sv
module cdbus_port_decoder
  import cdbus_pkg::*;
#(
  parameter int LOW_CYCLES = 2,
  parameter int ATTN_HALF  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic [SEL_W-1:0]  base_sel,
  input  logic              uart_dtr_n,
  input  logic              drv_dclk,
  input  logic              drv_data,
  input  logic              drv_attn,
  output logic              uart_data_sel,
  output logic              uart_ctrl_sel,
  output logic              rdy_rd,
  output logic              attn_rd,
  output logic              dp_reset,
  output logic              card_owns_bus,
  output logic              dma_permit,
  output logic              dclk_out,
  output logic              data_out,
  output logic              attn_out
);

  port_ev_e ev;
  logic     io_act;
  logic     io_q;
  logic     acc_go;
  logic     test_mode;
  logic     step_req;
  logic     gen_dclk;
  logic     gen_data;
  logic     gen_attn;
  logic     gen_busy;

  assign io_act    = !ior_n || !iow_n;
  assign acc_go    = io_act && !io_q;
  assign test_mode = uart_dtr_n;
  assign step_req  = acc_go && (ev == EV_STEP) && test_mode;

  cdbus_addr_match u_match (
    .addr     (addr),
    .base_sel (base_sel),
    .is_rd    (!ior_n),
    .ev       (ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_q     <= 1'b0;
      dp_reset <= 1'b0;
    end else begin
      io_q     <= io_act;
      dp_reset <= acc_go && (ev == EV_DPRST);
    end
  end

  assign uart_data_sel = io_act && (ev == EV_UDATA);
  assign uart_ctrl_sel = io_act && (ev == EV_UCTRL);
  assign rdy_rd        = io_act && (ev == EV_RDY);
  assign attn_rd       = io_act && (ev == EV_ATTN);
  assign card_owns_bus = test_mode;
  assign dma_permit    = !test_mode;

  cdbus_pulse_gen #(
    .LOW_CYCLES (LOW_CYCLES),
    .ATTN_HALF  (ATTN_HALF)
  ) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_req (step_req),
    .gen_dclk (gen_dclk),
    .gen_data (gen_data),
    .gen_attn (gen_attn),
    .busy     (gen_busy)
  );

  cdbus_bus_mux u_mux (
    .test_mode (test_mode),
    .gen_dclk  (gen_dclk),
    .gen_data  (gen_data),
    .gen_attn  (gen_attn),
    .drv_dclk  (drv_dclk),
    .drv_data  (drv_data),
    .drv_attn  (drv_attn),
    .dclk_out  (dclk_out),
    .data_out  (data_out),
    .attn_out  (attn_out)
  );

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({uart_data_sel, uart_ctrl_sel, rdy_rd, attn_rd})); // R3
  AST_DPRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dp_reset |=> !dp_reset); // R4
  AST_DPRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dp_reset |-> $past(io_act)); // R10
  AST_PULSE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gen_dclk) |-> $past(uart_dtr_n)); // R8
  AST_BUSY_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    gen_busy |-> !gen_dclk); // R6

endmodule

// File: tb/cdbus_port_decoder_tb.sv
`timescale 1ns/1ps
module cdbus_port_decoder_tb;

  localparam int LOW = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] addr = '0;
  logic       ior_n = 1'b1;
  logic       iow_n = 1'b1;
  logic [2:0] base_sel = '0;
  logic       uart_dtr_n = 1'b1;
  logic       drv_dclk = 1'b1;
  logic       drv_data = 1'b0;
  logic       drv_attn = 1'b0;
  logic       uart_data_sel, uart_ctrl_sel, rdy_rd, attn_rd, dp_reset;
  logic       card_owns_bus, dma_permit, dclk_out, data_out, attn_out;

  int checks = 0;
  int errors = 0;
  int pulse_n = 0;
  logic cur_data = 1'b0;
  logic cur_attn = 1'b0;

  always #2.5 clk = ~clk;

  cdbus_port_decoder #(.LOW_CYCLES(LOW), .ATTN_HALF(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ior_n(ior_n), .iow_n(iow_n),
    .base_sel(base_sel), .uart_dtr_n(uart_dtr_n), .drv_dclk(drv_dclk),
    .drv_data(drv_data), .drv_attn(drv_attn), .uart_data_sel(uart_data_sel),
    .uart_ctrl_sel(uart_ctrl_sel), .rdy_rd(rdy_rd), .attn_rd(attn_rd),
    .dp_reset(dp_reset), .card_owns_bus(card_owns_bus), .dma_permit(dma_permit),
    .dclk_out(dclk_out), .data_out(data_out), .attn_out(attn_out)
  );

  function automatic bit b_hit(input logic [9:0] a, input logic [2:0] s);
    return (s <= 3'd4) && (a[9:4] == 6'(6'h30 + {3'b000, s}));
  endfunction

  function automatic bit b_data(input int n);
    return (n % 2) == 0;
  endfunction

  function automatic bit b_attn(input int n);
    return (n % 128) < 64;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_lines(input string tag);
    if (uart_dtr_n) begin
      chk({tag, " R7 data"}, 32'(data_out), 32'(cur_data));
      chk({tag, " R7 attn"}, 32'(attn_out), 32'(cur_attn));
    end else begin
      chk({tag, " R5 pass dclk"}, 32'(dclk_out), 32'(drv_dclk));
      chk({tag, " R5 pass data"}, 32'(data_out), 32'(drv_data));
      chk({tag, " R5 pass attn"}, 32'(attn_out), 32'(drv_attn));
    end
    chk({tag, " R5 owns"}, 32'(card_owns_bus), 32'(uart_dtr_n));
    chk({tag, " R5 dma"}, 32'(dma_permit), 32'(!uart_dtr_n));
  endtask

  // One access held for LOW+2 cycles, then released for one idle cycle.
  task automatic access(input logic [9:0] a, input bit rd);
    bit hit;
    bit step;
    logic [3:0] off;
    off = a[3:0];
    @(negedge clk);
    addr  = a;
    ior_n = !rd;
    iow_n = rd;
    hit   = b_hit(a, base_sel);
    step  = hit && (off == 4'd8 || off == 4'd9) && uart_dtr_n;
    if (step) begin
      cur_data = b_data(pulse_n);
      cur_attn = b_attn(pulse_n);
      pulse_n++;
    end
    #1;
    chk("R1 R2 udata", 32'(uart_data_sel), 32'(hit && off == 4'd2));
    chk("R1 R2 uctrl", 32'(uart_ctrl_sel), 32'(hit && off == 4'd3));
    chk("R3 rdy", 32'(rdy_rd), 32'(hit && rd && (off == 4'd4 || off == 4'd5)));
    chk("R3 attn rd", 32'(attn_rd), 32'(hit && rd && (off == 4'd6 || off == 4'd7)));
    for (int c = 1; c <= LOW + 2; c++) begin
      @(negedge clk);
      chk("R4 R10 dp_reset", 32'(dp_reset), 32'(c == 1 && hit && off == 4'd0));
      if (uart_dtr_n)
        chk("R6 R10 dclk", 32'(dclk_out), 32'(!(step && c <= LOW)));
      chk_lines("R6");
    end
    ior_n = 1'b1;
    iow_n = 1'b1;
    @(negedge clk);
    chk("R4 idle", 32'(dp_reset), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 dclk", 32'(dclk_out), 32'd1);
    chk("R9 data", 32'(data_out), 32'd0);
    chk("R9 attn", 32'(attn_out), 32'd0);
    chk("R9 dp_reset", 32'(dp_reset), 32'd0);
    chk("R9 R5 owns", 32'(card_owns_bus), 32'd1);

    // Directed decode corners on every select value, including 5..7 (R1)
    for (int s = 0; s < 8; s++) begin
      base_sel = 3'(s);
      access(10'h300 + 10'(s * 16) + 10'd2, 1'b1);
      access(10'h300 + 10'(s * 16), 1'b0);
      access(10'h300 + 10'(s * 16) + 10'd5, 1'b0);
      access(10'h300 + 10'(s * 16) + 10'd7, 1'b1);
    end

    // Long stepping run across the attention boundaries (R7)
    base_sel = 3'd1;
    for (int i = 0; i < 270; i++)
      access(10'h318 + 10'(i % 2), i[1]);

    // Re-access inside the low phase must be ignored (R8)
    base_sel = 3'd0;
    @(negedge clk);
    addr = 10'h308; iow_n = 1'b0;
    cur_data = b_data(pulse_n); cur_attn = b_attn(pulse_n); pulse_n++;
    @(negedge clk);
    chk("R8 first low", 32'(dclk_out), 32'd0);
    iow_n = 1'b1;
    @(negedge clk);
    addr = 10'h309; ior_n = 1'b0;
    @(negedge clk);
    chk("R8 no restart", 32'(dclk_out), 32'd1);
    @(negedge clk);
    chk("R8 still high", 32'(dclk_out), 32'd1);
    chk_lines("R8 held");
    ior_n = 1'b1;
    @(negedge clk);
    access(10'h309, 1'b0);

    // Steps while DTR active do not advance the pattern (R8, R5)
    @(negedge clk);
    uart_dtr_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      drv_dclk = 1'($urandom); drv_data = 1'($urandom); drv_attn = 1'($urandom);
      access(10'h308, 1'($urandom));
    end
    @(negedge clk);
    uart_dtr_n = 1'b1;
    #1;
    chk_lines("R8 after dtr");
    access(10'h308, 1'b1);

    // Constrained random mix
    for (int i = 0; i < 500; i++) begin
      logic [9:0] a;
      @(negedge clk);
      base_sel = 3'($urandom % 8);
      uart_dtr_n = ($urandom % 100) < 85;
      drv_dclk = 1'($urandom); drv_data = 1'($urandom); drv_attn = 1'($urandom);
      if (($urandom % 10) < 7)
        a = {6'(6'h30 + 6'($urandom % 6)), 4'($urandom)};
      else
        a = 10'($urandom);
      access(a, 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule